// File: doc/BRIEF.md
# Multi-channel DDR sample serializer

This block turns parallel sample words from up to eight converter channels into one double-data-rate bit stream per lane. It runs on a fast clock whose every cycle carries one bit pair, so a data clock toggling at that rate moves two bits per period. Alongside the lanes it produces a two-bit frame marker, which is high for the first half of each word's bits and low for the rest, and an enable for the data clock. The half-bit shift between data and clock edges is left to the output stage that follows.

Samples are captured on a strobe and moved into the serializer at each word boundary. Plain configuration inputs choose a 12-bit or 10-bit word, the bit order, twos complement or offset binary coding, a test source (alternating checkerboard, PN9 sequence or a fixed user word) and a per-lane power-down. A sync pulse restarts the word divider on a known edge.

Top module: `adc_ddr_framer`

## Requirements
- R1: In 12-bit mode a word takes 6 clock cycles and goes out MSB first. In each cycle the lane's upper bit (lane_o[2c+1]) carries the earlier bit of the pair and lane_o[2c] the later one.
- R2: With lsb_first_i=1 the word goes out starting from its least significant transmitted bit.
- R3: With res10_i=1 a word takes 5 cycles and carries only sample bits [11:2]. The MSB-first order sends bit 11 first, and the LSB-first order sends bit 2 first.
- R4: The frame marker uses the same pairing as the lanes (frame_o[1] earlier). It is 1 for the first W/2 bits of each word and 0 for the rest, where W is 12 or 10.
- R5: With offset_bin_i=1 converter data has its bit 11 inverted, which turns twos complement into offset binary. Test patterns are sent without this change.
- R6: A sync_i pulse makes the next cycle the first pair of a word. That word holds the sample last captured by sample_stb_i, and later words follow without gaps.
- R7: tp_mode_i=01 sends 0xAAA and then 0x555 alternately, one per word. The first word after the mode is entered is 0xAAA.
- R8: tp_mode_i=10 sends a PN9 sequence, state s with next state {s[7:0], s[8]^s[4]} and word {s, s[8:6]}. The sequence advances once per word and restarts at s=0x1FF when the mode is entered.
- R9: tp_mode_i=11 sends tp_user_i on every lane.
- R10: A powered-down lane (pdwn_i[c]=1) outputs 0. Frame and dclk_en_o keep running while any lane is up, and both go to 0 when all lanes are down.
- R11: In reset every lane is 0, the divider sits at the first pair (frame_o=2'b11 in 12-bit mode) and dclk_en_o is 1 while a lane is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-pair clock |
| rst_n | input | 1 | Active-low reset |
| sync_i | input | 1 | Restart word divider |
| sample_stb_i | input | 1 | Capture sample_i |
| sample_i | input | NCH*12 | Per-channel twos complement samples, channel c at [12c+11:12c] |
| res10_i | input | 1 | 10-bit word mode |
| lsb_first_i | input | 1 | LSB-first order |
| offset_bin_i | input | 1 | Offset binary coding |
| tp_mode_i | input | 2 | 00 data, 01 checkerboard, 10 PN9, 11 user |
| tp_user_i | input | 12 | User test word |
| pdwn_i | input | NCH | Per-lane power-down |
| lane_o | output | NCH*2 | Bit pairs, lane c at [2c+1:2c] |
| frame_o | output | 2 | Frame marker bit pair |
| dclk_en_o | output | 1 | Data clock enable |

## Verification
On every cycle the assertions check several things. The divider must step by one or wrap, a sync must bring it back to the first pair, and a frame marker may rise only on a word's first pair. A lane that stays powered down must stay silent, and entering the PN9 mode must reseed the generator. Only the bench scenarios can show that whole words come back correctly, because that needs bit order, resolution, coding and the pattern sequences to be rebuilt across several cycles.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;
    localparam int WORD_W  = 12;
    localparam int SHORT_W = 10;
    localparam int CNT_W   = 3;
    localparam int PN_W    = 9;

    typedef enum logic [1:0] {
        TP_OFF  = 2'b00,
        TP_CHK  = 2'b01,
        TP_PN9  = 2'b10,
        TP_USER = 2'b11
    } tp_mode_e;
endpackage

// File: rtl/adc_tp_gen.sv
module adc_tp_gen
    import adc_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [WORD_W-1:0] user_i,
    input  logic              load_i,
    output logic              tp_en_o,
    output logic [WORD_W-1:0] tp_word_o
);
    typedef struct packed {
        logic [PN_W-1:0] lfsr;
        logic            alt;
        logic [1:0]      mode;
    } tp_state_t;

    tp_state_t st_q, st_d;
    logic            entering;
    logic [PN_W-1:0] cur_lfsr;
    logic            cur_alt;

    always_comb begin
        entering = (mode_i != st_q.mode);
        cur_lfsr = (entering && mode_i == TP_PN9) ? {PN_W{1'b1}} : st_q.lfsr;
        cur_alt  = (entering && mode_i == TP_CHK) ? 1'b0 : st_q.alt;
        tp_en_o  = (mode_i != TP_OFF);
        unique case (mode_i)
            TP_CHK:  tp_word_o = cur_alt ? 12'h555 : 12'hAAA;
            TP_PN9:  tp_word_o = {cur_lfsr, cur_lfsr[PN_W-1:PN_W-3]};
            TP_USER: tp_word_o = user_i;
            default: tp_word_o = '0;
        endcase
        st_d      = st_q;
        st_d.mode = mode_i;
        st_d.lfsr = (load_i && mode_i == TP_PN9)
                  ? {cur_lfsr[PN_W-2:0], cur_lfsr[8] ^ cur_lfsr[4]} : cur_lfsr;
        st_d.alt  = (load_i && mode_i == TP_CHK) ? ~cur_alt : cur_alt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lfsr <= {PN_W{1'b1}};
            st_q.alt  <= 1'b0;
            st_q.mode <= TP_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: entering PN9 without a word load leaves the seed in place
    a_r8_pn_reseed: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TP_PN9 && st_q.mode != TP_PN9 && !load_i) |=> (st_q.lfsr == 9'h1FF));
endmodule

// File: rtl/adc_lane_ser.sv
module adc_lane_ser
    import adc_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [WORD_W-1:0] sample_i,
    input  logic              load_i,
    input  logic              tp_en_i,
    input  logic [WORD_W-1:0] tp_word_i,
    input  logic              offbin_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              res10_i,
    input  logic              lsb_first_i,
    input  logic              pdwn_i,
    output logic [1:0]        bits_o
);
    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] word;
    } lane_state_t;

    lane_state_t st_q, st_d;
    logic [WORD_W-1:0] src;
    logic [3:0] j0, j1, i0, i1, base;

    always_comb begin
        src = tp_en_i ? tp_word_i
                      : (offbin_i ? (st_q.hold ^ {1'b1, {(WORD_W-1){1'b0}}}) : st_q.hold);
        st_d      = st_q;
        st_d.hold = stb_i ? sample_i : st_q.hold;
        st_d.word = load_i ? src : st_q.word;
        j0   = {cnt_i, 1'b0};
        j1   = {cnt_i, 1'b1};
        base = res10_i ? 4'(WORD_W - SHORT_W) : 4'd0;
        i0   = lsb_first_i ? base + j0 : 4'(WORD_W - 1) - j0;
        i1   = lsb_first_i ? base + j1 : 4'(WORD_W - 1) - j1;
        bits_o = pdwn_i ? 2'b00 : {st_q.word[i0], st_q.word[i1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a lane held powered down stays silent
    a_r10_pdwn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pdwn_i && $past(pdwn_i)) |-> (bits_o == 2'b00));
endmodule

// File: rtl/adc_ddr_framer.sv
module adc_ddr_framer
    import adc_framer_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_i,
    input  logic                  sample_stb_i,
    input  logic [NCH*WORD_W-1:0] sample_i,
    input  logic                  res10_i,
    input  logic                  lsb_first_i,
    input  logic                  offset_bin_i,
    input  logic [1:0]            tp_mode_i,
    input  logic [WORD_W-1:0]     tp_user_i,
    input  logic [NCH-1:0]        pdwn_i,
    output logic [NCH*2-1:0]      lane_o,
    output logic [1:0]            frame_o,
    output logic                  dclk_en_o
);
    localparam int PAIRS_L = WORD_W / 2;
    localparam int PAIRS_S = SHORT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_q, st_d;
    logic [CNT_W-1:0] last_pair;
    logic [3:0]       half, j0;
    logic             load, active, tp_en;
    logic [WORD_W-1:0] tp_word;

    always_comb begin
        last_pair = res10_i ? CNT_W'(PAIRS_S - 1) : CNT_W'(PAIRS_L - 1);
        half      = res10_i ? 4'(SHORT_W / 2) : 4'(WORD_W / 2);
        load      = sync_i || (st_q.cnt >= last_pair);
        st_d.cnt  = load ? '0 : st_q.cnt + 1'b1;
        active    = |(~pdwn_i);
        j0        = {st_q.cnt, 1'b0};
        dclk_en_o = active;
        frame_o   = active ? {(j0 < half), ((j0 + 4'd1) < half)} : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    adc_tp_gen u_tp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (tp_mode_i),
        .user_i    (tp_user_i),
        .load_i    (load),
        .tp_en_o   (tp_en),
        .tp_word_o (tp_word)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        adc_lane_ser u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .stb_i       (sample_stb_i),
            .sample_i    (sample_i[c*WORD_W +: WORD_W]),
            .load_i      (load),
            .tp_en_i     (tp_en),
            .tp_word_i   (tp_word),
            .offbin_i    (offset_bin_i),
            .cnt_i       (st_q.cnt),
            .res10_i     (res10_i),
            .lsb_first_i (lsb_first_i),
            .pdwn_i      (pdwn_i[c]),
            .bits_o      (lane_o[2*c +: 2])
        );
    end

    // R6: a sync pulse puts the divider on the first pair next cycle
    a_r6_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (st_q.cnt == '0));

    // R1: without sync the divider steps by one inside a word
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && st_q.cnt < last_pair) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R4: a frame rise while clocks run marks the first pair of a word
    a_r4_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_en_o && $past(dclk_en_o) && $rose(frame_o[1])) |-> (st_q.cnt == '0));
endmodule

// File: tb/adc_ddr_framer_test.sv
module adc_ddr_framer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    // {res10, lsb_first, offset_bin, 1'b0, sample[11:0]}
    localparam logic [15:0] VEC [0:5] = '{
        16'h0A5C, 16'h4123, 16'h8F0E, 16'hC7B1, 16'h2800, 16'hE3C9
    };

    logic clk = 0, rst_n = 0, sync_i = 0, stb = 0;
    logic [NCH*12-1:0] sample = '0;
    logic res10 = 0, lsb = 0, offb = 0;
    logic [1:0] tpm = 2'b00;
    logic [11:0] tpu = '0;
    logic [NCH-1:0] pdwn = '0;
    logic [NCH*2-1:0] lane_o;
    logic [1:0] frame_o;
    logic dclk_en_o;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [11:0] got [NCH];
    logic [11:0] got_f;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_ddr_framer #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sample_stb_i(stb),
        .sample_i(sample), .res10_i(res10), .lsb_first_i(lsb),
        .offset_bin_i(offb), .tp_mode_i(tpm), .tp_user_i(tpu),
        .pdwn_i(pdwn), .lane_o(lane_o), .frame_o(frame_o), .dclk_en_o(dclk_en_o)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [NCH*12-1:0] v);
        sample = v; stb = 1;
        @(negedge clk) stb = 0;
    endtask

    // samples one whole word on every lane, starting at the current negedge
    task automatic capture();
        int w = res10 ? 10 : 12;
        logic [11:0] rx [NCH];
        logic [11:0] fr = '0;
        for (int c = 0; c < NCH; c++) rx[c] = '0;
        for (int k = 0; k < w/2; k++) begin
            for (int c = 0; c < NCH; c++) begin
                rx[c][2*k]   = lane_o[2*c+1];
                rx[c][2*k+1] = lane_o[2*c];
            end
            fr[2*k] = frame_o[1]; fr[2*k+1] = frame_o[0];
            @(negedge clk);
        end
        got_f = fr;
        for (int c = 0; c < NCH; c++) begin
            got[c] = '0;
            for (int j = 0; j < w; j++) begin
                if (lsb) got[c][12-w+j] = rx[c][j];
                else     got[c][11-j]   = rx[c][j];
            end
        end
    endtask

    task automatic sync_capture();
        sync_i = 1;
        @(negedge clk) sync_i = 0;
        capture();
    endtask

    function automatic logic [11:0] frame_exp(input logic r10);
        return r10 ? 12'h01F : 12'h03F;
    endfunction

    function automatic logic [11:0] chan_sample(input logic [11:0] b, input int c);
        return b ^ 12'(c * 12'h111);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] exp;
        logic [8:0] s;
        // R11: reset state
        #(CLK_PERIOD*2 + 1);
        check("R11 lanes in reset", 12'(lane_o), 12'h000);
        check("R11 frame in reset", {10'd0, frame_o}, 12'h003);
        check("R11 dclk_en in reset", {11'd0, dclk_en_o}, 12'h001);
        @(negedge clk) rst_n = 1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6: vector table
        foreach (VEC[i]) begin
            logic [NCH*12-1:0] v;
            for (int c = 0; c < NCH; c++) v[c*12 +: 12] = chan_sample(VEC[i][11:0], c);
            strobe(v);
            @(negedge clk);
            res10 = VEC[i][15]; lsb = VEC[i][14]; offb = VEC[i][13];
            sync_capture();
            for (int c = 0; c < NCH; c++) begin
                exp = chan_sample(VEC[i][11:0], c);
                if (offb) exp = exp ^ 12'h800;
                if (res10) exp = exp & 12'hFFC;
                check($sformatf("R1 R2 R3 R5 R6 vec%0d lane%0d", i, c), got[c], exp);
            end
            check($sformatf("R4 frame vec%0d", i), got_f, frame_exp(res10));
        end

        // R6: sync mid-word, then back-to-back words hold the same sample
        res10 = 0; lsb = 0; offb = 0;
        strobe({NCH{12'h3C5}});
        @(negedge clk); @(negedge clk);
        sync_capture();
        check("R6 sync mid-word", got[0], 12'h3C5);
        capture();
        check("R6 next word no gap", got[5], 12'h3C5);
        check("R4 frame second word", got_f, 12'h03F);

        // R7: checkerboard
        tpm = 2'b01;
        sync_capture();
        check("R7 first word", got[2], 12'hAAA);
        capture();
        check("R7 second word", got[2], 12'h555);
        capture();
        check("R7 third word", got[7], 12'hAAA);

        // R8: PN9
        tpm = 2'b10; offb = 1;
        s = 9'h1FF;
        sync_capture();
        for (int n = 0; n < 4; n++) begin
            if (n > 0) capture();
            check($sformatf("R8 pn word%0d", n), got[1], {s, s[8:6]});
            s = {s[7:0], s[8] ^ s[4]};
        end

        // R9: user word, coding not applied
        tpm = 2'b11; tpu = 12'h123;
        sync_capture();
        check("R9 user lane0", got[0], 12'h123);
        check("R9 user lane6", got[6], 12'h123);
        tpm = 2'b00; offb = 0;

        // R10: one lane down, others normal
        strobe({NCH{12'h9E1}});
        pdwn = 8'h08;
        sync_capture();
        check("R10 down lane zero", got[3], 12'h000);
        check("R10 up lane", got[4], 12'h9E1);
        check("R10 frame runs", got_f, 12'h03F);
        pdwn = 8'hFF;
        @(negedge clk);
        check("R10 all down lanes", 12'(lane_o), 12'h000);
        check("R10 all down frame", {10'd0, frame_o}, 12'h000);
        check("R10 all down dclk_en", {11'd0, dclk_en_o}, 12'h000);
        pdwn = '0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule